// File: doc/BRIEF.md
# Byte-Stuffed Frame Transmitter

This block turns one message into a framed byte stream for a byte-oriented serial link that has no framing of its own. A message is a command byte, which may be followed by an address byte and then by any number of payload bytes. It arrives as a valid/ready byte stream, and a last-byte marker closes it. The block writes an opening flag and then the message bytes. Next comes a CRC-8 of the raw message bytes, and a closing flag ends the frame. Any message or CRC byte that would collide with one of the three control values is replaced by an escape flag followed by the bitwise inverse of that byte.

The output is a valid/ready byte stream for a UART transmitter. When a new message is already waiting as a frame closes, its opening flag follows the closing flag in the very next cycle. The block does not track command meaning, addressing or retries. An address byte is treated like any other message byte.

Top module: `stuffed_frame_tx`

## Requirements
- R1: After reset, with no message offered, out_valid and in_ready are both low.
- R2: A frame opens with the byte 0x02, which is emitted while in_ready is low and before any message byte is accepted.
- R3: A message byte that is not 0x02, 0x03 or 0x1B appears on out_data unchanged, and it is accepted on the input in the same cycle that it is accepted on the output.
- R4: A message byte equal to 0x02, 0x03 or 0x1B is emitted as 0x1B followed by its bitwise inverse (0xFD, 0xFC or 0xE4).
- R5: While the 0x1B of an escape pair is on the output, in_ready stays low. The input byte is accepted together with its inverted copy.
- R6: After the last message byte, the block emits the CRC-8 of all raw message bytes in arrival order (command, address and payload). The CRC uses polynomial 0x1D, MSB first, initial value 0x00 and no final XOR.
- R7: A CRC value equal to 0x02, 0x03 or 0x1B is sent as 0x1B followed by its inverse.
- R8: Every frame ends with 0x03 directly after the CRC byte or the CRC escape pair.
- R9: A message of only a command byte yields 0x02, the (possibly escaped) command, the (possibly escaped) CRC and 0x03.
- R10: When the next message is already offered, the opening 0x02 of the next frame is accepted in the cycle right after the closing 0x03, provided out_ready stays high.
- R11: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change in the next cycle.
- R12: The CRC restarts from 0x00 for every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Message byte |
| in_valid | input | 1 | Message byte offered |
| in_last | input | 1 | Offered byte is the last of its message |
| in_ready | output | 1 | Message byte accepted this cycle |
| out_data | output | 8 | Framed byte toward the serial transmitter |
| out_valid | output | 1 | Framed byte offered |
| out_ready | input | 1 | Transmitter takes the framed byte |

## Verification
Each of the 256 values is sent as a one-byte message. Because the CRC of a single byte is a bijection, this sweep escapes every command value that collides with a control byte and every CRC value that does. Addressed messages of growing length mix plain bytes with control values, which separates correct pass-through from wrong escape insertion and shows whether the CRC is taken over raw or stuffed bytes. A payload made only of control values, sent under random backpressure, exercises the input stall across every escape pair and the stability of held outputs. A burst of back-to-back messages with constant readiness measures the gap between the closing flag and the next opening flag.

// File: rtl/stuffed_frame_tx.sv
module stuffed_frame_tx #(
  parameter int          W          = 8,
  parameter logic [W-1:0] START_FLAG = 8'h02,
  parameter logic [W-1:0] STOP_FLAG  = 8'h03,
  parameter logic [W-1:0] ESC_FLAG   = 8'h1B,
  parameter logic [W-1:0] CRC_POLY   = 8'h1D,
  parameter logic [W-1:0] CRC_INIT   = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  input  logic         in_last,
  output logic         in_ready,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  input  logic         out_ready
);

  typedef enum logic [2:0] {S_SOF, S_MSG, S_MESC, S_CRC, S_CESC, S_EOF} st_t;

  st_t          st;
  logic [W-1:0] crc;

  function automatic logic is_ctrl(input logic [W-1:0] b);
    return (b == START_FLAG) || (b == STOP_FLAG) || (b == ESC_FLAG);
  endfunction

  function automatic logic [W-1:0] crc_step(input logic [W-1:0] c, input logic [W-1:0] b);
    logic [W-1:0] r;
    r = c ^ b;
    for (int i = 0; i < W; i++)
      r = r[W-1] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction

  wire          in_ctrl  = is_ctrl(in_data);
  wire          crc_ctrl = is_ctrl(crc);
  wire          fire     = out_valid && out_ready;
  wire [W-1:0]  crc_nxt  = crc_step(crc, in_data);

  always_comb begin
    out_valid = 1'b0;
    out_data  = START_FLAG;
    in_ready  = 1'b0;
    case (st)
      S_SOF: begin
        out_valid = in_valid;
        out_data  = START_FLAG;
      end
      S_MSG: begin
        out_valid = in_valid;
        if (in_ctrl) begin
          out_data = ESC_FLAG;
        end else begin
          out_data = in_data;
          in_ready = out_ready;
        end
      end
      S_MESC: begin
        out_valid = in_valid;
        out_data  = ~in_data;
        in_ready  = out_ready;
      end
      S_CRC: begin
        out_valid = 1'b1;
        out_data  = crc_ctrl ? ESC_FLAG : crc;
      end
      S_CESC: begin
        out_valid = 1'b1;
        out_data  = ~crc;
      end
      S_EOF: begin
        out_valid = 1'b1;
        out_data  = STOP_FLAG;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_SOF;
      crc <= CRC_INIT;
    end else if (fire) begin
      case (st)
        S_SOF: begin
          st  <= S_MSG;
          crc <= CRC_INIT;
        end
        S_MSG: begin
          if (in_ctrl) begin
            st <= S_MESC;
          end else begin
            crc <= crc_nxt;
            st  <= in_last ? S_CRC : S_MSG;
          end
        end
        S_MESC: begin
          crc <= crc_nxt;
          st  <= in_last ? S_CRC : S_MSG;
        end
        S_CRC:   st <= crc_ctrl ? S_CESC : S_EOF;
        S_CESC:  st <= S_EOF;
        S_EOF:   st <= S_SOF;
        default: st <= S_SOF;
      endcase
    end
  end

endmodule

// File: rtl/stuffed_frame_tx_chk.sv
module stuffed_frame_tx_chk #(
  parameter int          W       = 8,
  parameter logic [W-1:0] START_F = 8'h02,
  parameter logic [W-1:0] STOP_F  = 8'h03,
  parameter logic [W-1:0] ESC_F   = 8'h1B
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] out_data,
  input logic         out_valid,
  input logic         out_ready
);

  assert_sof_holds_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data == START_F) |-> !in_ready);

  assert_take_with_emit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (out_valid && out_ready));

  assert_esc_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_data == ESC_F) |=>
      (out_valid && (out_data == ~START_F || out_data == ~STOP_F || out_data == ~ESC_F)));

  assert_esc_blocks_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data == ESC_F) |-> !in_ready);

  assert_eof_holds_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data == STOP_F) |-> !in_ready);

  assert_stall_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind stuffed_frame_tx stuffed_frame_tx_chk #(
  .W(W), .START_F(START_FLAG), .STOP_F(STOP_FLAG), .ESC_F(ESC_FLAG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/sim_stuffed_frame_tx.sv
module sim_stuffed_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b0;

  always #2 clk = ~clk;

  stuffed_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int rmode = 3;
  bit do_rst_chk = 0;
  bit gap_en = 0;
  int last_stop = -1;
  bit stall_pend = 0;
  logic [7:0] stall_d = 8'h00;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] msg[64];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
    if (!gap_en) last_stop = -1;
    if (do_rst_chk)
      chk(!out_valid && !in_ready, "R1", {out_valid, in_ready}, 0);
    if (rst_n) begin
      if (stall_pend)
        chk(out_valid && out_data == stall_d, "R11", {out_valid, out_data}, {1'b1, stall_d});
      stall_pend = out_valid && !out_ready;
      stall_d    = out_data;
      if (out_valid && out_data == 8'h1B)
        chk(!in_ready, "R5", in_ready, 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 extra byte", out_data, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data == e, t, out_data, e);
        end
        if (gap_en && out_data == 8'h02 && last_stop >= 0)
          chk(cyc == last_stop + 1, "R10 gap", cyc - last_stop, 1);
        if (out_data == 8'h03) last_stop = cyc;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1;
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom & 1) != 0;
        2: out_ready = (cyc % 4) != 0;
        default: out_ready = 1'b0;
      endcase
    end
  end

  function automatic bit is_ctrl(input logic [7:0] b);
    return b == 8'h02 || b == 8'h03 || b == 8'h1B;
  endfunction

  // CRC as remainder of M(x)*x^8 divided by x^8+x^4+x^3+x^2+1
  function automatic logic [7:0] ref_crc(input int n);
    logic [7:0] r;
    logic       top;
    r = 8'h00;
    for (int i = 0; i < n * 8 + 8; i++) begin
      logic b;
      b = (i < n * 8) ? msg[i / 8][7 - (i % 8)] : 1'b0;
      top = r[7];
      r = {r[6:0], b};
      if (top) r = r ^ 8'h1D;
    end
    return r;
  endfunction

  task automatic push_stuffed(input logic [7:0] b, input string plain_t, input string esc_t);
    if (is_ctrl(b)) begin
      exp_q.push_back(8'h1B); tag_q.push_back(esc_t);
      exp_q.push_back(~b);    tag_q.push_back(esc_t);
    end else begin
      exp_q.push_back(b);     tag_q.push_back(plain_t);
    end
  endtask

  task automatic put(input logic [7:0] b, input bit l);
    in_data  = b;
    in_last  = l;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send(input int n);
    string sfx;
    sfx = (n == 1) ? " R9" : "";
    exp_q.push_back(8'h02); tag_q.push_back({"R2", sfx});
    for (int i = 0; i < n; i++)
      push_stuffed(msg[i], {"R3", sfx}, {"R4", sfx});
    push_stuffed(ref_crc(n), {"R6 R12", sfx}, {"R7", sfx});
    exp_q.push_back(8'h03); tag_q.push_back({"R8", sfx});
    for (int i = 0; i < n; i++)
      put(msg[i], i == n - 1);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    do_rst_chk = 1'b1;
    @(posedge clk); #1;
    rmode = 0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    do_rst_chk = 1'b0;

    for (int v = 0; v < 256; v++) begin
      if (v == 128) rmode = 1;
      msg[0] = v[7:0];
      send(1);
    end
    drain();

    rmode = 2;
    for (int len = 0; len <= 20; len++) begin
      msg[0] = 8'h80 | len[7:0];
      msg[1] = len[7:0] * 8'd7;
      for (int k = 0; k < len; k++) begin
        if (k % 3 == 0)
          msg[2 + k] = (k % 9 == 0) ? 8'h02 : ((k % 9 == 3) ? 8'h1B : 8'h03);
        else
          msg[2 + k] = 8'((k * 37 + len) & 8'hFF);
      end
      send(len + 2);
    end
    drain();

    rmode = 1;
    for (int k = 0; k < 30; k++)
      msg[k] = (k % 3 == 0) ? 8'h02 : ((k % 3 == 1) ? 8'h03 : 8'h1B);
    send(30);
    drain();

    rmode = 0;
    gap_en = 1'b1;
    for (int f = 0; f < 6; f++) begin
      for (int k = 0; k < f + 1; k++)
        msg[k] = 8'((f * 53 + k * 11 + 1) & 8'hFF);
      send(f + 1);
    end
    drain();
    gap_en = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule